// File: doc/BRIEF.md
# Timer Control and Status Word

This block keeps the control word of one physical countdown timer and drives that timer's level interrupt. Software writes a 64-bit word to it and reads the same word back. Two bits of that word are stored: an enable bit and an interrupt mask bit. A third bit is a status flag that the block computes itself.

The block takes the free-running system counter and the timer's compare value as inputs. The timer condition holds when the counter, compared as an unsigned number, is greater than or equal to the compare value.

The status flag shows that condition whenever the timer is enabled, whatever the mask says. The interrupt line is a registered output. It rises only when the timer is enabled, the condition holds and the mask is clear. Clearing enable silences the interrupt, but the countdown value (compare minus counter) keeps moving with the counter.

Top module: `timer_ctl_reg`

## Requirements
- R1: A write stores bit 0 of the written word as the enable bit and bit 1 as the mask bit. Both read back at the same positions from the clock edge that takes the write, and they hold their value while no write occurs.
- R2: Bits 63 down to 3 of the read word are always 0, and writing ones to them has no effect.
- R3: While enable is 1, read bit 2 (status) is 1 exactly when count_i >= cmp_i (unsigned), whatever the value of the mask bit.
- R4: While enable is 0, read bit 2 is 0.
- R5: Bit 2 is read-only: writing 1 or 0 there changes neither the stored state nor the read value.
- R6: irq_o is a register. After each clock edge it equals enable AND condition AND NOT mask, as those stood just before that edge.
- R7: While rst_ni is low, enable, mask and irq_o are all 0.
- R8: tval_o always equals cmp_i minus count_i, modulo 2^64, whether or not the timer is enabled.
- R9: The comparison is unsigned: a counter with bit 63 set meets a small compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 64 | Word to write (bit 0 enable, bit 1 mask) |
| count_i | input | 64 | System counter value |
| cmp_i | input | 64 | Compare value |
| rd_data_o | output | 64 | Control word read view (bit 2 status) |
| tval_o | output | 64 | Countdown value, cmp_i minus count_i |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bench runs every enable and mask pair with the counter one below, equal to and one above the compare value.

Each corner case targets a specific fault:
- A comparator that uses > instead of >= misses the equal case.
- A status bit gated by the mask hides status while masked.
- A design that resets the countdown on disable shows a wrong tval_o.

A signed compare would fail the check with bit 63 of the counter set. A write to bit 2 that leaks into storage shows up in the next read. An unregistered interrupt shows up one cycle early in the check that compares it with the previous cycle's state.

// File: rtl/tmr_ctl_pkg.sv
package tmr_ctl_pkg;
  localparam int unsigned EN_BIT  = 0;
  localparam int unsigned MSK_BIT = 1;
  localparam int unsigned STS_BIT = 2;
  localparam int unsigned CTL_USED = 3;

  typedef struct packed {
    logic mask;
    logic en;
  } ctl_t;
endpackage

// File: rtl/tmr_ctl_store.sv
module tmr_ctl_store
  import tmr_ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_bits_i,
  output ctl_t       ctl_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (wr_en_i) begin
      ctl_q.en   <= wr_bits_i[EN_BIT];
      ctl_q.mask <= wr_bits_i[MSK_BIT];
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/tmr_ctl_cond.sv
module tmr_ctl_cond #(
  parameter int unsigned CNT_W = 64
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             met_o,
  output logic [CNT_W-1:0] remain_o
);
  // unsigned difference; borrow clear means count >= cmp
  logic [CNT_W:0] diff;

  assign diff     = {1'b0, count_i} - {1'b0, cmp_i};
  assign met_o    = ~diff[CNT_W];
  assign remain_o = cmp_i - count_i;
endmodule

// File: rtl/tmr_ctl_irq.sv
module tmr_ctl_irq
  import tmr_ctl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  ctl_t ctl_i,
  input  logic met_i,
  output logic status_o,
  output logic irq_o
);
  logic irq_q;

  assign status_o = ctl_i.en & met_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= status_o & ~ctl_i.mask;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/timer_ctl_reg.sv
module timer_ctl_reg
  import tmr_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CNT_W-1:0]  cmp_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  tval_o,
  output logic              irq_o
);
  ctl_t ctl;
  logic met;
  logic status;
  logic unused_wr;

  assign unused_wr = ^{wr_data_i[DATA_W-1:CTL_USED], wr_data_i[STS_BIT]};

  tmr_ctl_store u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_bits_i(wr_data_i[1:0]),
    .ctl_o    (ctl)
  );

  tmr_ctl_cond #(.CNT_W(CNT_W)) u_cond (
    .count_i (count_i),
    .cmp_i   (cmp_i),
    .met_o   (met),
    .remain_o(tval_o)
  );

  tmr_ctl_irq u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctl_i   (ctl),
    .met_i   (met),
    .status_o(status),
    .irq_o   (irq_o)
  );

  for (genvar b = 0; b < DATA_W; b++) begin : g_rd
    if (b == EN_BIT) begin : g_en
      assign rd_data_o[b] = ctl.en;
    end else if (b == MSK_BIT) begin : g_msk
      assign rd_data_o[b] = ctl.mask;
    end else if (b == STS_BIT) begin : g_sts
      assign rd_data_o[b] = status;
    end else begin : g_zero
      assign rd_data_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/timer_ctl_reg_chk.sv
module timer_ctl_reg_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_ctl_i,
  input logic [CNT_W-1:0]  count_i,
  input logic [CNT_W-1:0]  cmp_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              irq_o
);
  AST_CTL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[1:0] == $past(wr_ctl_i)); // R1
  AST_CTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o[1:0])); // R1
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:3] == '0); // R2
  AST_STATUS_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[0] |-> rd_data_o[2] == (count_i >= cmp_i)); // R3
  AST_STATUS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[0] |-> !rd_data_o[2]); // R4
  AST_IRQ_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(rd_data_o[0] & rd_data_o[2] & ~rd_data_o[1])); // R6

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RST_CLEAR: assert (rd_data_o[1:0] == 2'b00 && !irq_o); // R7
    end
  end
endmodule

bind timer_ctl_reg timer_ctl_reg_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_ctl_i (wr_data_i[1:0]),
  .count_i  (count_i),
  .cmp_i    (cmp_i),
  .rd_data_o(rd_data_o),
  .irq_o    (irq_o)
);

// File: tb/tb_timer_ctl_reg.sv
`timescale 1ns/1ps
module tb_timer_ctl_reg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [63:0] wr_data_i = '0;
  logic [63:0] count_i = '0;
  logic [63:0] cmp_i = '0;
  logic [63:0] rd_data_o;
  logic [63:0] tval_o;
  logic        irq_o;

  timer_ctl_reg dut (.*);

  always #2.5 clk_i = ~clk_i;

  typedef struct {
    logic [63:0] rd;
    logic [63:0] tval;
    logic        irq;
    string       req;
  } item_t;

  item_t sb_q[$];
  int n_vec = 0;
  int n_bad = 0;
  logic en_m = 1'b0, mk_m = 1'b0;
  bit done = 0;

  task automatic step(input logic wr, input logic [63:0] data,
                      input logic [63:0] cnt, input logic [63:0] cmp, input string req);
    item_t it;
    logic cond;
    @(negedge clk_i);
    wr_en_i = wr; wr_data_i = data; count_i = cnt; cmp_i = cmp;
    cond = (cnt >= cmp);
    it.irq = en_m & cond & ~mk_m;      // sampled with pre-edge state (R6)
    if (wr) begin en_m = data[0]; mk_m = data[1]; end
    it.rd   = {61'd0, en_m & cond, mk_m, en_m};
    it.tval = cmp - cnt;
    it.req  = req;
    sb_q.push_back(it);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk_i); #1;
      if (sb_q.size() > 0) begin
        item_t e;
        e = sb_q.pop_front();
        n_vec++;
        if (rd_data_o !== e.rd || tval_o !== e.tval || irq_o !== e.irq) begin
          n_bad++;
          $display("FAIL %s: rd=%h tval=%h irq=%b expected rd=%h tval=%h irq=%b",
                   e.req, rd_data_o, tval_o, irq_o, e.rd, e.tval, e.irq);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] base;
    // R7: reset state
    repeat (3) @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = 64'h3; count_i = 64'd9; cmp_i = 64'd1;
    @(posedge clk_i); #1;
    n_vec++;
    if (rd_data_o !== 64'd0 || irq_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R7: rd=%h irq=%b expected rd=0 irq=0", rd_data_o, irq_o);
    end
    @(negedge clk_i);
    wr_en_i = 1'b0;
    rst_ni = 1'b1;

    // R1 R3 R4 R6: all enable/mask pairs across the compare boundary
    base = 64'h0000_0100_0000_0000;
    for (int m = 0; m < 4; m++) begin
      step(1'b1, 64'(m), base - 1, base, "R1");
      for (int d = -1; d <= 1; d++) begin
        step(1'b0, 64'h0, base + 64'(d), base, "R3/R4/R6");
        step(1'b0, 64'h0, base + 64'(d), base, "R6");
      end
    end

    // R2 R5: all-ones write, reserved and status bits ignored
    step(1'b1, 64'hFFFF_FFFF_FFFF_FFFC, 64'd5, 64'd10, "R2/R5");
    step(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 64'd10, "R2");
    step(1'b0, 64'h0, 64'd10, 64'd10, "R3");
    step(1'b1, 64'h0000_0000_0000_0004, 64'd10, 64'd10, "R5");
    step(1'b0, 64'h0, 64'd11, 64'd10, "R4/R5");

    // R9: unsigned compare, counter MSB set
    step(1'b1, 64'h1, 64'h8000_0000_0000_0000, 64'd3, "R9");
    step(1'b0, 64'h0, 64'h8000_0000_0000_0000, 64'd3, "R9/R6");
    step(1'b0, 64'h0, 64'd3, 64'h8000_0000_0000_0000, "R9");

    // R8: countdown continues while disabled
    step(1'b1, 64'h0, 64'd100, 64'd200, "R8");
    for (int k = 0; k < 6; k++)
      step(1'b0, 64'h0, 64'd150 + 64'(k * 40), 64'd200, "R8/R4");
    step(1'b1, 64'h1, 64'd400, 64'd200, "R8/R3");
    step(1'b0, 64'h0, 64'd400, 64'd200, "R6");
    // R1: hold without write
    step(1'b0, 64'h2, 64'd400, 64'd200, "R1");
    step(1'b1, 64'h2, 64'd400, 64'd200, "R1");
    step(1'b0, 64'h0, 64'd400, 64'd200, "R6");

    @(posedge clk_i); #2;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule